// File: doc/BRIEF.md
# Rotating-Priority Multithread Issue Scheduler

This block sits in the schedule stage of a processor that runs several hardware threads side by side. Each thread slot may present one decoded instruction per cycle. The instruction carries the index of the functional unit it needs and an opaque payload tag. The scheduler gives each functional unit to at most one slot per cycle, choosing by a priority order across the slots. It then reports, per unit, whether an operation starts and from which slot and tag.

A request that loses arbitration is not thrown away. It moves into a one-entry standby latch owned by its slot and competes again in later cycles at that slot's current priority. Meanwhile the slot's decoder may keep sending instructions for other units.

The priority order is a ring that rotates so that no slot starves. Rotation is either timed, with a power-of-two interval, or driven by software, where only the slot at the top of the ring may trigger it. The load/store unit needs two cycles between operations. Every other unit accepts one operation per cycle.

Top module: `sched_issue`

## Requirements
- R1: The slot named by `top_slot` has the highest priority, and priority falls in increasing cyclic slot index from there. When several candidates target the same free unit, the unit is granted to the highest-priority one.
- R2: Candidates that target distinct free units are all granted in the same cycle as they are presented, with no register between request and grant. `iss_slot` gives the winning slot and `iss_tag` gives its tag.
- R3: A new request that loses arbitration while its slot's latch is empty, or while the latch is being drained in that cycle, is accepted (`dec_take`=1) and stored. From the next cycle it competes again with its original tag until it is granted, and then the latch empties.
- R4: While a slot's latch holds an instruction and is not drained, a new request from that slot is refused (`dec_take`=0) if it targets the same unit as the held instruction. A new request to a different unit competes normally and is accepted if granted.
- R5: Unit 3 is the load/store unit and is never granted in the cycle right after it was granted. Units 0, 1 and 2 can be granted in every cycle.
- R6: A rotation moves `top_slot` to the next slot index modulo 4. The old top becomes lowest, and every other slot rises one level.
- R7: When `explicit_mode`=0, a rotation happens every 2^`rot_shift` cycles, counting from the cycle in which timed mode starts. A `rot_shift` above 8 counts as 8, so the interval ranges from 1 to 256 cycles. The interval counter is held at zero while `explicit_mode`=1.
- R8: When `explicit_mode`=1, a rotation happens only in a cycle where `chg_pri[top_slot]` is 1. `chg_pri` bits of other slots are ignored, and a rotation is a single step even if all bits are set.
- R9: After reset, `top_slot` is 0, every latch is empty, and no unit is marked busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| explicit_mode | input | 1 | Privileged control: 1 selects software-driven rotation, 0 selects timed rotation |
| rot_shift | input | 4 | Timed rotation interval as a power of two, clamped at 8 |
| chg_pri | input | 4 | Per-slot change-priority strobe |
| req_valid | input | 4 | Per-slot new instruction present |
| req_unit | input | 4x2 | Per-slot target unit index |
| req_tag | input | 4x8 | Per-slot instruction payload |
| dec_take | output | 1x4 | Per-slot: the new instruction was consumed (issued or stored) |
| standby_full | output | 4 | Per-slot standby latch occupied |
| iss_valid | output | 4 | Per-unit operation starts this cycle |
| iss_slot | output | 4x2 | Per-unit winning slot |
| iss_tag | output | 4x8 | Per-unit payload of the winning instruction |
| top_slot | output | 2 | Slot currently holding the highest priority |

## Verification
On every cycle, the assertions check the following. Rotation only ever advances by one slot. Software mode never rotates without a strobe from the top slot. The load/store unit always leaves a gap after each grant. Every grant traces back to a live request or an occupied latch. A refused request only happens while its slot's latch is full. Which slot wins a contention, the exact tag that drains from a latch, and the exact length of the timed interval, including the clamp at 256 cycles, depend on the sequence of events. Only the directed scenarios of the bench show these.

// File: rtl/sched_pkg.sv
package sched_pkg;
    parameter int NSLOT     = 4;
    parameter int SLOT_W    = $clog2(NSLOT);
    parameter int NUNIT     = 4;
    parameter int UNIT_W    = $clog2(NUNIT);
    parameter int TAG_W     = 8;
    parameter logic [NUNIT-1:0] LS_MASK = 4'b1000;
    parameter int SHIFT_W   = 4;
    parameter int MAX_SHIFT = 8;
    localparam int CNT_W    = MAX_SHIFT;

    typedef struct packed {
        logic              vld;
        logic [UNIT_W-1:0] unit;
        logic [TAG_W-1:0]  tag;
    } op_t;

    function automatic logic [CNT_W-1:0] interval_last(input logic [SHIFT_W-1:0] sh);
        logic [SHIFT_W-1:0] s;
        logic [CNT_W:0]     span;
        s    = (sh > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : sh;
        span = (CNT_W+1)'(1) << s;
        return CNT_W'(span - (CNT_W+1)'(1));
    endfunction
endpackage

// File: rtl/sched_rotor.sv
module sched_rotor
    import sched_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               explicit_mode,
    input  logic [SHIFT_W-1:0] rot_shift,
    input  logic [NSLOT-1:0]   chg_pri,
    output logic [SLOT_W-1:0]  top_slot
);
    logic [SLOT_W-1:0] top_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last;
    logic              expired;
    logic              rot_now;

    always_comb begin
        last    = interval_last(rot_shift);
        expired = (cnt_q >= last);
        rot_now = explicit_mode ? chg_pri[top_q] : expired;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            cnt_q <= '0;
        end else begin
            if (rot_now)
                top_q <= SLOT_W'((int'(top_q) + 1) % NSLOT);
            if (explicit_mode || expired)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign top_slot = top_q;
endmodule

// File: rtl/sched_arb.sv
module sched_arb
    import sched_pkg::*;
(
    input  logic [NSLOT-1:0]  req,
    input  logic [SLOT_W-1:0] top,
    input  logic              blocked,
    output logic [NSLOT-1:0]  gnt
);
    always_comb begin
        logic              found;
        logic [SLOT_W-1:0] idx;
        gnt   = '0;
        found = blocked;
        for (int k = 0; k < NSLOT; k++) begin
            idx = SLOT_W'((int'(top) + k) % NSLOT);
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sched_standby.sv
module sched_standby
    import sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  op_t  load_op,
    input  logic drain,
    output op_t  held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (load)
            held <= load_op;
        else if (drain)
            held.vld <= 1'b0;
    end
endmodule

// File: rtl/sched_issue.sv
module sched_issue
    import sched_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             explicit_mode,
    input  logic [SHIFT_W-1:0]               rot_shift,
    input  logic [NSLOT-1:0]                 chg_pri,
    input  logic [NSLOT-1:0]                 req_valid,
    input  logic [NSLOT-1:0][UNIT_W-1:0]     req_unit,
    input  logic [NSLOT-1:0][TAG_W-1:0]      req_tag,
    output logic [NSLOT-1:0]                 dec_take,
    output logic [NSLOT-1:0]                 standby_full,
    output logic [NUNIT-1:0]                 iss_valid,
    output logic [NUNIT-1:0][SLOT_W-1:0]     iss_slot,
    output logic [NUNIT-1:0][TAG_W-1:0]      iss_tag,
    output logic [SLOT_W-1:0]                top_slot
);
    op_t                          held [NSLOT];
    op_t                          new_op [NSLOT];
    logic [NSLOT-1:0]             new_ok, held_gnt, new_gnt, sb_load, sb_drain;
    logic [NUNIT-1:0][NSLOT-1:0]  req_m, gnt_m;
    logic [NUNIT-1:0]             busy_q;

    sched_rotor u_rotor (
        .clk           (clk),
        .rst           (rst),
        .explicit_mode (explicit_mode),
        .rot_shift     (rot_shift),
        .chg_pri       (chg_pri),
        .top_slot      (top_slot)
    );

    // candidate building: held entry plus an eligible new request per slot
    always_comb begin
        req_m = '0;
        for (int s = 0; s < NSLOT; s++) begin
            new_op[s] = '{vld: req_valid[s], unit: req_unit[s], tag: req_tag[s]};
            new_ok[s] = req_valid[s] && !(held[s].vld && held[s].unit == req_unit[s]);
            if (held[s].vld)
                req_m[held[s].unit][s] = 1'b1;
            if (new_ok[s])
                req_m[req_unit[s]][s] = 1'b1;
        end
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        sched_arb u_arb (
            .req     (req_m[u]),
            .top     (top_slot),
            .blocked (busy_q[u]),
            .gnt     (gnt_m[u])
        );
    end

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            held_gnt[s]     = held[s].vld && gnt_m[held[s].unit][s];
            new_gnt[s]      = new_ok[s] && gnt_m[req_unit[s]][s];
            sb_drain[s]     = held_gnt[s];
            sb_load[s]      = new_ok[s] && !new_gnt[s] && (!held[s].vld || held_gnt[s]);
            dec_take[s]     = new_gnt[s] || sb_load[s];
            standby_full[s] = held[s].vld;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        sched_standby u_sb (
            .clk     (clk),
            .rst     (rst),
            .load    (sb_load[s]),
            .load_op (new_op[s]),
            .drain   (sb_drain[s]),
            .held    (held[s])
        );
    end

    always_comb begin
        for (int u = 0; u < NUNIT; u++) begin
            iss_valid[u] = |gnt_m[u];
            iss_slot[u]  = '0;
            iss_tag[u]   = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (gnt_m[u][s]) begin
                    iss_slot[u] = SLOT_W'(s);
                    iss_tag[u]  = (held[s].vld && held[s].unit == UNIT_W'(u)) ?
                                  held[s].tag : req_tag[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= '0;
        else
            busy_q <= iss_valid & LS_MASK;
    end
endmodule

// File: rtl/sched_issue_chk.sv
module sched_issue_chk
    import sched_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         explicit_mode,
    input logic [NSLOT-1:0]             chg_pri,
    input logic [NSLOT-1:0]             req_valid,
    input logic [NSLOT-1:0]             dec_take,
    input logic [NSLOT-1:0]             standby_full,
    input logic [NUNIT-1:0]             iss_valid,
    input logic [NUNIT-1:0][SLOT_W-1:0] iss_slot,
    input logic [SLOT_W-1:0]            top_slot
);
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (top_slot == '0 && standby_full == '0));

    a_r6_rotate_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(top_slot) |-> top_slot == SLOT_W'((int'($past(top_slot)) + 1) % NSLOT));

    a_r8_explicit_hold: assert property (@(posedge clk) disable iff (rst)
        (explicit_mode && !chg_pri[top_slot]) |=> $stable(top_slot));

    for (genvar s = 0; s < NSLOT; s++) begin : g_s
        a_r3_take_needs_req: assert property (@(posedge clk) disable iff (rst)
            dec_take[s] |-> req_valid[s]);
        a_r4_refuse_when_full: assert property (@(posedge clk) disable iff (rst)
            (req_valid[s] && !dec_take[s]) |-> standby_full[s]);
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_u
        a_r2_grant_has_source: assert property (@(posedge clk) disable iff (rst)
            iss_valid[u] |-> (req_valid[iss_slot[u]] || standby_full[iss_slot[u]]));
        if (LS_MASK[u]) begin : g_ls
            a_r5_ls_gap: assert property (@(posedge clk) disable iff (rst)
                iss_valid[u] |=> !iss_valid[u]);
        end
    end
endmodule

bind sched_issue sched_issue_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .explicit_mode (explicit_mode),
    .chg_pri       (chg_pri),
    .req_valid     (req_valid),
    .dec_take      (dec_take),
    .standby_full  (standby_full),
    .iss_valid     (iss_valid),
    .iss_slot      (iss_slot),
    .top_slot      (top_slot)
);

// File: tb/sched_issue_tb.sv
module sched_issue_tb;
    import sched_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                         clk = 1'b0;
    logic                         rst;
    logic                         explicit_mode;
    logic [SHIFT_W-1:0]           rot_shift;
    logic [NSLOT-1:0]             chg_pri;
    logic [NSLOT-1:0]             req_valid;
    logic [NSLOT-1:0][UNIT_W-1:0] req_unit;
    logic [NSLOT-1:0][TAG_W-1:0]  req_tag;
    logic [NSLOT-1:0]             dec_take;
    logic [NSLOT-1:0]             standby_full;
    logic [NUNIT-1:0]             iss_valid;
    logic [NUNIT-1:0][SLOT_W-1:0] iss_slot;
    logic [NUNIT-1:0][TAG_W-1:0]  iss_tag;
    logic [SLOT_W-1:0]            top_slot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sched_issue u_dut (
        .clk (clk), .rst (rst), .explicit_mode (explicit_mode), .rot_shift (rot_shift),
        .chg_pri (chg_pri), .req_valid (req_valid), .req_unit (req_unit), .req_tag (req_tag),
        .dec_take (dec_take), .standby_full (standby_full), .iss_valid (iss_valid),
        .iss_slot (iss_slot), .iss_tag (iss_tag), .top_slot (top_slot)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_reqs();
        req_valid = '0;
        req_unit  = '0;
        req_tag   = '0;
        chg_pri   = '0;
    endtask

    task automatic put(input int s, input int u, input int tag);
        req_valid[s] = 1'b1;
        req_unit[s]  = UNIT_W'(u);
        req_tag[s]   = TAG_W'(tag);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        settle();
        chk("R9", "top after reset", int'(top_slot), 0);
        chk("R9", "standby after reset", int'(standby_full), 0);
        chk("R9", "no issue after reset", int'(iss_valid), 0);
    endtask

    task automatic t_parallel();
        clear_reqs();
        for (int s = 0; s < NSLOT; s++) put(s, s, 8'h10 + s);
        settle();
        chk("R2", "all units issue", int'(iss_valid), 15);
        chk("R2", "all taken", int'(dec_take), 15);
        for (int u = 0; u < NUNIT; u++) begin
            chk("R2", "unit slot", int'(iss_slot[u]), u);
            chk("R2", "unit tag", int'(iss_tag[u]), 8'h10 + u);
        end
        step(); clear_reqs();
        // the load/store unit was granted in the previous cycle
        put(1, 3, 8'h21);
        settle();
        chk("R5", "ls unit busy after grant", int'(iss_valid[3]), 0);
        step(); clear_reqs(); settle();
        chk("R5", "ls held one drains", int'(iss_valid[3]), 1);
        chk("R5", "ls held tag", int'(iss_tag[3]), 8'h21);
        step(); settle();
    endtask

    task automatic t_conflict();
        clear_reqs();
        put(1, 0, 8'h41);
        put(2, 0, 8'h42);
        settle();
        chk("R1", "top0 slot1 beats slot2", int'(iss_slot[0]), 1);
        chk("R3", "loser taken into latch", int'(dec_take[2]), 1);
        step(); clear_reqs(); settle();
        chk("R3", "latch occupied", int'(standby_full[2]), 1);
        chk("R3", "held issues", int'(iss_valid[0]), 1);
        chk("R3", "held slot", int'(iss_slot[0]), 2);
        chk("R3", "held tag kept", int'(iss_tag[0]), 8'h42);
        step(); settle();
        chk("R3", "latch empties", int'(standby_full[2]), 0);
    endtask

    task automatic t_ls();
        clear_reqs();
        put(0, 3, 8'h30);
        settle();
        chk("R5", "ls first grant", int'(iss_valid[3]), 1);
        step(); clear_reqs();
        put(1, 3, 8'h31);
        settle();
        chk("R5", "ls gap", int'(iss_valid[3]), 0);
        chk("R3", "ls loser stored", int'(dec_take[1]), 1);
        step(); clear_reqs(); settle();
        chk("R5", "ls after gap", int'(iss_valid[3]), 1);
        chk("R5", "ls after gap tag", int'(iss_tag[3]), 8'h31);
        step(); settle();
    endtask

    task automatic t_explicit();
        clear_reqs();
        chg_pri = 4'b0100;
        step(); clear_reqs(); settle();
        chk("R8", "non-top strobe ignored", int'(top_slot), 0);
        chg_pri = 4'b0001;
        step(); clear_reqs(); settle();
        chk("R6", "top strobe rotates", int'(top_slot), 1);
        put(0, 1, 8'h60); put(1, 1, 8'h61);
        settle();
        chk("R1", "top1 slot1 beats slot0", int'(iss_slot[1]), 1);
        step(); clear_reqs(); step();
        put(0, 0, 8'h62); put(3, 0, 8'h63);
        settle();
        chk("R1", "top1 slot3 beats slot0", int'(iss_slot[0]), 3);
        step(); clear_reqs(); step();
    endtask

    task automatic t_standby();
        clear_reqs();
        put(1, 2, 8'hA1); put(0, 2, 8'h50);
        settle();
        chk("R3", "slot0 stored", int'(dec_take[0]), 1);
        step(); clear_reqs();
        put(1, 2, 8'hA2); put(0, 2, 8'h51);
        settle();
        chk("R4", "same unit refused", int'(dec_take[0]), 0);
        chk("R5", "unit2 back to back", int'(iss_slot[2]), 1);
        step(); clear_reqs();
        put(1, 2, 8'hA3); put(0, 0, 8'h52);
        settle();
        chk("R4", "latch still full", int'(standby_full[0]), 1);
        chk("R4", "other unit taken", int'(dec_take[0]), 1);
        chk("R4", "other unit issues", int'(iss_valid[0]), 1);
        chk("R4", "other unit tag", int'(iss_tag[0]), 8'h52);
        step(); clear_reqs(); settle();
        chk("R3", "old held drains", int'(iss_slot[2]), 0);
        chk("R3", "old held tag", int'(iss_tag[2]), 8'h50);
        step(); settle();
        chk("R3", "latch empty", int'(standby_full[0]), 0);
    endtask

    task automatic t_wrap();
        clear_reqs();
        chg_pri = 4'b0010; step(); clear_reqs();
        chg_pri = 4'b0100; step(); clear_reqs(); settle();
        chk("R6", "top reaches 3", int'(top_slot), 3);
        chg_pri = 4'b1111; step(); clear_reqs(); settle();
        chk("R6", "wrap to 0 single step", int'(top_slot), 0);
        repeat (20) step();
        settle();
        chk("R8", "no strobe no rotate", int'(top_slot), 0);
    endtask

    task automatic t_timer();
        int t0;
        clear_reqs();
        rot_shift = 4'd2;
        explicit_mode = 1'b0;
        t0 = int'(top_slot);
        repeat (3) step();
        settle();
        chk("R7", "no rotate before 4", int'(top_slot), t0);
        step(); settle();
        chk("R7", "rotate at 4", int'(top_slot), (t0 + 1) % NSLOT);
        repeat (4) step();
        settle();
        chk("R7", "rotate at 8", int'(top_slot), (t0 + 2) % NSLOT);
        rot_shift = 4'd0;
        step(); settle();
        chk("R7", "interval 1 a", int'(top_slot), (t0 + 3) % NSLOT);
        step(); settle();
        chk("R7", "interval 1 b", int'(top_slot), (t0 + 4) % NSLOT);
        rot_shift = 4'd13;
        repeat (255) step();
        settle();
        chk("R7", "clamp no rotate at 255", int'(top_slot), (t0 + 4) % NSLOT);
        step(); settle();
        chk("R7", "clamp rotate at 256", int'(top_slot), (t0 + 5) % NSLOT);
        explicit_mode = 1'b1;
    endtask

    initial begin
        rst = 1'b1;
        explicit_mode = 1'b1;
        rot_shift = 4'd3;
        clear_reqs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        step(); t_parallel();
        step(); t_conflict();
        step(); t_ls();
        step(); t_explicit();
        t_standby();
        t_wrap();
        t_timer();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule